// File: doc/BRIEF.md
# Debug Port Pushed-Write and Pushed-Compare Engine

This block sits between a host-side register interface and a memory access port of a debug port. The host programs a run length, a transfer mode, a byte-lane mask and a start address. Each data word then pushed by the host becomes one access-port transaction at the next word address. In the plain mode the word is written. In the two compare modes the engine reads the target word instead of writing it, compares it with the pushed word on the selected byte lanes, and records the outcome in a sticky compare flag.

The engine keeps the run counter and a set of status flags: a sticky transaction-fault flag, the sticky compare flag, a write-data fault flag and a read-response flag. A parameter selects how the sticky flags are cleared. In the abort style, clear bits on a separate abort write clear them. In the self-clear style, writing 1 to the flag bits in the configuration write clears them. A power-up bit drives a clock-run request output.

The pushed-word input is a valid/ready stream. `push_ready` is high only when the engine is idle and no configuration write is present in the same cycle. A word moves on a cycle where `push_valid` and `push_ready` are both high, and the host holds the word until that cycle. On the access-port side one request is outstanding at a time. `ap_req` and its address, data and direction stay stable until the cycle in which `ap_ack` is high.

Top module: `dbg_push_engine`

## Requirements
- R1: After reset, `xfer_left`, all flags, `ap_req` and `clk_run_req` are 0, and `push_ready` is 1.
- R2: A configuration write while idle loads the run length into `xfer_left` and latches the mode, the lane mask and the start address.
- R3: In mode 0, and in mode 3 (reserved, behaves as mode 0), each accepted word issues one access-port write (`ap_write`=1) at the current address, carrying the pushed word.
- R4: Each transaction that completes with `ap_ok`=1 decrements `xfer_left` by one and advances the address by 4 bytes.
- R5: In mode 1 and mode 2, an accepted word issues an access-port read (`ap_write`=0) at the current address. The target is not written.
- R6: Byte lane n (bits 8n+7:8n) takes part in the compare only when mask bit n is 1. With a mask of 0 every compare matches.
- R7: On an OK compare response, mode 1 sets `cmp_flag` when the words differ and mode 2 sets it when they match. Once set, the flag stays set until it is cleared.
- R8: An error response (`ap_ok`=0) sets `fault_flag` and leaves both `xfer_left` and the address unchanged.
- R9: A word accepted while `fault_flag` is 1 or `xfer_left` is 0 is discarded without any access-port request, and it sets `wdata_fault`.
- R10: A pulse on `wdata_err` sets `wdata_fault`. An abort write with `abort_clr_wdf`=1 clears it.
- R11: `rd_good` takes the `ap_ok` value of every read response, and write responses leave it unchanged.
- R12: With SELF_CLEAR=0, abort clear bits clear `fault_flag` and `cmp_flag` and the configuration clear bits have no effect. With SELF_CLEAR=1 the roles are swapped. A set in the same cycle takes priority over a clear.
- R13: `clk_run_req` follows the power-up bit of the last configuration write.
- R14: `push_ready` is low while a request is outstanding, and `ap_req` holds with a stable address and data until `ap_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_count | input | CNT_W | Run length to load |
| cfg_mode | input | 2 | Mode: 0 write, 1 set on mismatch, 2 set on match, 3 as 0 |
| cfg_mask | input | DATA_W/8 | Byte-lane compare mask |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_pwrup | input | 1 | Clock-run request bit |
| cfg_clr_fault | input | 1 | Self-clear style: clear fault flag |
| cfg_clr_cmp | input | 1 | Self-clear style: clear compare flag |
| abort_wr | input | 1 | Abort write strobe |
| abort_clr_fault | input | 1 | Abort style: clear fault flag |
| abort_clr_cmp | input | 1 | Abort style: clear compare flag |
| abort_clr_wdf | input | 1 | Clear write-data fault flag |
| wdata_err | input | 1 | Parity or framing error pulse from the write data phase |
| push_valid | input | 1 | Pushed word valid |
| push_ready | output | 1 | Engine can take a word |
| push_data | input | DATA_W | Pushed word |
| ap_req | output | 1 | Access-port request |
| ap_write | output | 1 | 1 write, 0 read |
| ap_addr | output | ADDR_W | Access-port byte address |
| ap_wdata | output | DATA_W | Pushed word for the request |
| ap_ack | input | 1 | Response present |
| ap_ok | input | 1 | Response OK (1) or error (0) |
| ap_rdata | input | DATA_W | Read data |
| xfer_left | output | CNT_W | Transactions remaining |
| fault_flag | output | 1 | Sticky transaction fault |
| cmp_flag | output | 1 | Sticky compare result |
| wdata_fault | output | 1 | Write-data fault flag |
| rd_good | output | 1 | Last read response was OK |
| clk_run_req | output | 1 | Clock-run request |

## Verification
The bench pushes words when the counter is zero and while a fault is latched. A design that still issues the access gets an unexpected request on the scoreboard. A design that forgets the write-data fault leaves that flag low. Compares are driven with partial masks, with a mask of zero, and with both compare polarities, so an inverted lane mask or a swapped mode shows up as a wrong compare flag. After an error response, the next transaction must go to the same address with the count unchanged. A second instance in self-clear style checks that each clear path reaches only its own flavour.

// File: rtl/dbg_push_pkg.sv
package dbg_push_pkg;

  typedef enum logic [1:0] {
    PMODE_WRITE  = 2'd0,
    PMODE_CMP_NE = 2'd1,
    PMODE_CMP_EQ = 2'd2,
    PMODE_RSVD   = 2'd3
  } push_mode_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_REQ  = 1'b1
  } seq_state_e;

  function automatic logic is_cmp_mode(push_mode_e m);
    return (m == PMODE_CMP_NE) || (m == PMODE_CMP_EQ);
  endfunction

endpackage

// File: rtl/dpp_lane_cmp.sv
module dpp_lane_cmp #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] word_a,
  input  logic [LANES*8-1:0] word_b,
  input  logic [LANES-1:0]   lane_en,
  output logic               all_match
);
  logic [LANES-1:0] lane_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ok[g] = !lane_en[g] || (word_a[g*8 +: 8] == word_b[g*8 +: 8]);
  end

  assign all_match = &lane_ok;
endmodule

// File: rtl/dpp_seq.sv
module dpp_seq
  import dbg_push_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_mode,
  input  logic [LANES-1:0]  cfg_mask,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              fault_flag,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              ap_req,
  output logic              ap_write,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_wdata,
  input  logic              ap_ack,
  input  logic              ap_ok,
  output logic [CNT_W-1:0]  xfer_left,
  output push_mode_e        mode_q,
  output logic [LANES-1:0]  mask_q,
  output logic              drop
);
  localparam int STEP = DATA_W / 8;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;
  logic              blocked;
  logic              push_fire;

  assign push_ready = (state_q == SEQ_IDLE) && !cfg_wr;
  assign push_fire  = push_valid && push_ready;
  assign blocked    = fault_flag || (cnt_q == '0);
  assign drop       = push_fire && blocked;

  assign ap_req    = (state_q == SEQ_REQ);
  assign ap_write  = !is_cmp_mode(mode_q);
  assign ap_addr   = addr_q;
  assign ap_wdata  = hold_q;
  assign xfer_left = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      hold_q  <= '0;
      mode_q  <= PMODE_WRITE;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cfg_wr) begin
            cnt_q  <= cfg_count;
            addr_q <= cfg_addr;
            mode_q <= push_mode_e'(cfg_mode);
            mask_q <= cfg_mask;
          end else if (push_fire && !blocked) begin
            hold_q  <= push_data;
            state_q <= SEQ_REQ;
          end
        end
        SEQ_REQ: begin
          if (ap_ack) begin
            state_q <= SEQ_IDLE;
            if (ap_ok) begin
              cnt_q  <= cnt_q - 1'b1;
              addr_q <= addr_q + ADDR_W'(STEP);
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req && !ap_ack |=> ap_req && $stable(ap_addr) && $stable(ap_wdata)); // R14

  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !ap_req); // R9

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req && ap_ack && ap_ok |=> xfer_left == CNT_W'($past(xfer_left) - 1'b1)); // R4

  AST_ERR_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req && ap_ack && !ap_ok |=> $stable(xfer_left) && $stable(ap_addr)); // R8
endmodule

// File: rtl/dpp_flags.sv
module dpp_flags
  import dbg_push_pkg::*;
#(
  parameter bit SELF_CLEAR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resp_valid,
  input  logic       resp_ok,
  input  logic       resp_read,
  input  push_mode_e mode,
  input  logic       match,
  input  logic       drop,
  input  logic       wdata_err,
  input  logic       cfg_wr,
  input  logic       cfg_clr_fault,
  input  logic       cfg_clr_cmp,
  input  logic       abort_wr,
  input  logic       abort_clr_fault,
  input  logic       abort_clr_cmp,
  input  logic       abort_clr_wdf,
  output logic       fault_flag,
  output logic       cmp_flag,
  output logic       wdata_fault,
  output logic       rd_good
);
  logic clr_fault, clr_cmp, clr_wdf;
  logic set_fault, set_cmp, set_wdf;
  logic cmp_hit;

  if (SELF_CLEAR) begin : g_self
    assign clr_fault = cfg_wr && cfg_clr_fault;
    assign clr_cmp   = cfg_wr && cfg_clr_cmp;
  end else begin : g_abort
    assign clr_fault = abort_wr && abort_clr_fault;
    assign clr_cmp   = abort_wr && abort_clr_cmp;
  end
  assign clr_wdf = abort_wr && abort_clr_wdf;

  assign cmp_hit   = (mode == PMODE_CMP_NE) ? !match : match;
  assign set_fault = resp_valid && !resp_ok;
  assign set_cmp   = resp_valid && resp_ok && is_cmp_mode(mode) && cmp_hit;
  assign set_wdf   = drop || wdata_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flag  <= 1'b0;
      cmp_flag    <= 1'b0;
      wdata_fault <= 1'b0;
      rd_good     <= 1'b0;
    end else begin
      if (set_fault)      fault_flag <= 1'b1;
      else if (clr_fault) fault_flag <= 1'b0;

      if (set_cmp)        cmp_flag <= 1'b1;
      else if (clr_cmp)   cmp_flag <= 1'b0;

      if (set_wdf)        wdata_fault <= 1'b1;
      else if (clr_wdf)   wdata_fault <= 1'b0;

      if (resp_valid && resp_read) rd_good <= resp_ok;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !clr_fault |=> fault_flag); // R12

  AST_WDF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> wdata_fault); // R9

  AST_RDGOOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_read |=> $stable(rd_good)); // R11

  AST_CMP_FROM_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(resp_valid && resp_ok && resp_read)); // R7
endmodule

// File: rtl/dbg_push_engine.sv
module dbg_push_engine
  import dbg_push_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 12,
  parameter bit SELF_CLEAR = 1'b0,
  localparam int LANES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_mode,
  input  logic [LANES-1:0]  cfg_mask,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_pwrup,
  input  logic              cfg_clr_fault,
  input  logic              cfg_clr_cmp,
  input  logic              abort_wr,
  input  logic              abort_clr_fault,
  input  logic              abort_clr_cmp,
  input  logic              abort_clr_wdf,
  input  logic              wdata_err,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              ap_req,
  output logic              ap_write,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_wdata,
  input  logic              ap_ack,
  input  logic              ap_ok,
  input  logic [DATA_W-1:0] ap_rdata,
  output logic [CNT_W-1:0]  xfer_left,
  output logic              fault_flag,
  output logic              cmp_flag,
  output logic              wdata_fault,
  output logic              rd_good,
  output logic              clk_run_req
);
  push_mode_e       mode_q;
  logic [LANES-1:0] mask_q;
  logic             drop;
  logic             match;
  logic             run_q;

  dpp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LANES(LANES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_addr(cfg_addr),
    .fault_flag(fault_flag),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .ap_req(ap_req), .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_ack(ap_ack), .ap_ok(ap_ok),
    .xfer_left(xfer_left), .mode_q(mode_q), .mask_q(mask_q), .drop(drop)
  );

  dpp_lane_cmp #(.LANES(LANES)) u_cmp (
    .word_a(ap_wdata), .word_b(ap_rdata), .lane_en(mask_q), .all_match(match)
  );

  dpp_flags #(.SELF_CLEAR(SELF_CLEAR)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .resp_valid(ap_req && ap_ack), .resp_ok(ap_ok), .resp_read(!ap_write),
    .mode(mode_q), .match(match), .drop(drop), .wdata_err(wdata_err),
    .cfg_wr(cfg_wr), .cfg_clr_fault(cfg_clr_fault), .cfg_clr_cmp(cfg_clr_cmp),
    .abort_wr(abort_wr), .abort_clr_fault(abort_clr_fault),
    .abort_clr_cmp(abort_clr_cmp), .abort_clr_wdf(abort_clr_wdf),
    .fault_flag(fault_flag), .cmp_flag(cmp_flag),
    .wdata_fault(wdata_fault), .rd_good(rd_good)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (cfg_wr) run_q <= cfg_pwrup;
  end
  assign clk_run_req = run_q;

  AST_CLKRUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> clk_run_req == $past(cfg_pwrup)); // R13
endmodule

// File: tb/test_dbg_push_engine.sv
module test_dbg_push_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 12;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic [DW-1:0] data;
  } ap_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_wr = 0, cfg_pwrup = 0, cfg_clr_fault = 0, cfg_clr_cmp = 0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_mode = '0;
  logic [3:0]    cfg_mask = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic abort_wr = 0, abort_clr_fault = 0, abort_clr_cmp = 0, abort_clr_wdf = 0;
  logic wdata_err = 0, push_valid = 0, inject_err = 0;
  logic [DW-1:0] push_data = '0;

  logic push_ready, ap_req, ap_write, ap_ack = 0, ap_ok = 1;
  logic [AW-1:0] ap_addr;
  logic [DW-1:0] ap_wdata, ap_rdata = '0;
  logic [CW-1:0] xfer_left;
  logic fault_flag, cmp_flag, wdata_fault, rd_good, clk_run_req;

  logic j_ready, j_req, j_write, j_fault, j_cmp, j_wdf, j_rdg, j_run;
  logic [AW-1:0] j_addr;
  logic [DW-1:0] j_wdata;
  logic [CW-1:0] j_left;

  int n_run = 0, n_fail = 0;
  ap_item_t exp_q[$];
  logic [DW-1:0] mem [16];

  dbg_push_engine i_dbg_push_engine (
    .clk, .rst_n, .cfg_wr, .cfg_count, .cfg_mode, .cfg_mask, .cfg_addr,
    .cfg_pwrup, .cfg_clr_fault, .cfg_clr_cmp, .abort_wr, .abort_clr_fault,
    .abort_clr_cmp, .abort_clr_wdf, .wdata_err, .push_valid, .push_ready,
    .push_data, .ap_req, .ap_write, .ap_addr, .ap_wdata, .ap_ack, .ap_ok,
    .ap_rdata, .xfer_left, .fault_flag, .cmp_flag, .wdata_fault, .rd_good,
    .clk_run_req
  );

  dbg_push_engine #(.SELF_CLEAR(1'b1)) i_self_clear (
    .clk, .rst_n, .cfg_wr, .cfg_count, .cfg_mode, .cfg_mask, .cfg_addr,
    .cfg_pwrup, .cfg_clr_fault, .cfg_clr_cmp, .abort_wr, .abort_clr_fault,
    .abort_clr_cmp, .abort_clr_wdf, .wdata_err, .push_valid, .push_ready(j_ready),
    .push_data, .ap_req(j_req), .ap_write(j_write), .ap_addr(j_addr),
    .ap_wdata(j_wdata), .ap_ack(j_req), .ap_ok(!inject_err), .ap_rdata('0),
    .xfer_left(j_left), .fault_flag(j_fault), .cmp_flag(j_cmp),
    .wdata_fault(j_wdf), .rd_good(j_rdg), .clk_run_req(j_run)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // access-port model and scoreboard monitor
  always @(negedge clk) begin
    if (ap_req && !ap_ack) begin
      ap_item_t it;
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R9: actual unexpected request at %0h expected none", ap_addr);
      end else begin
        it = exp_q.pop_front();
        check("R4 address", ap_addr, it.addr);
        check("R3/R5 direction", {31'b0, ap_write}, {31'b0, it.wr});
        check("R3 data", ap_wdata, it.data);
      end
      ap_rdata = mem[ap_addr[5:2]];
      ap_ok    = !inject_err;
      if (ap_write && !inject_err) mem[ap_addr[5:2]] = ap_wdata;
      ap_ack   = 1'b1;
    end else begin
      ap_ack = 1'b0;
    end
  end

  task automatic do_cfg(int cnt, int md, logic [3:0] mk, logic [31:0] ad,
                        logic pw, logic cf, logic cc);
    @(negedge clk);
    cfg_count = CW'(cnt); cfg_mode = 2'(md); cfg_mask = mk; cfg_addr = ad;
    cfg_pwrup = pw; cfg_clr_fault = cf; cfg_clr_cmp = cc; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_clr_fault = 1'b0; cfg_clr_cmp = 1'b0;
  endtask

  task automatic do_abort(logic cf, logic cc, logic cw);
    @(negedge clk);
    abort_clr_fault = cf; abort_clr_cmp = cc; abort_clr_wdf = cw; abort_wr = 1'b1;
    @(negedge clk);
    abort_wr = 1'b0; abort_clr_fault = 1'b0; abort_clr_cmp = 1'b0; abort_clr_wdf = 1'b0;
  endtask

  task automatic push_word(logic [31:0] d, logic issue, logic [31:0] ad, logic wr);
    if (issue) exp_q.push_back('{addr: ad, wr: wr, data: d});
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    while (!push_ready) @(negedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (push_ready) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(xfer_left), 0);
    check("R1 flags", {28'b0, fault_flag, cmp_flag, wdata_fault, rd_good}, 0);
    check("R1 req/run", {30'b0, ap_req, clk_run_req}, 0);
    check("R1 ready", {31'b0, push_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 push with zero count is dropped
    push_word(32'h1, 1'b0, 0, 1'b0);
    check("R9 wdata fault on zero count", {31'b0, wdata_fault}, 1);
    do_abort(1'b0, 1'b0, 1'b1);
    check("R10 wdata fault cleared", {31'b0, wdata_fault}, 0);

    // R2 / R3 / R4 plain writes
    do_cfg(3, 0, 4'hF, 32'h10, 1'b1, 1'b0, 1'b0);
    check("R2 count loaded", 32'(xfer_left), 3);
    check("R13 clock run on", {31'b0, clk_run_req}, 1);
    @(negedge clk);
    push_valid = 1'b1; push_data = 32'hDEAD0001;
    exp_q.push_back('{addr: 32'h10, wr: 1'b1, data: 32'hDEAD0001});
    @(negedge clk);
    push_valid = 1'b0;
    check("R14 ready low while busy", {31'b0, push_ready}, 0);
    @(negedge clk);
    check("R4 count after first", 32'(xfer_left), 2);
    push_word(32'hCAFE0002, 1'b1, 32'h14, 1'b1);
    check("R4 count after second", 32'(xfer_left), 1);
    push_word(32'h12345603, 1'b1, 32'h18, 1'b1);
    check("R4 count after third", 32'(xfer_left), 0);
    push_word(32'h5, 1'b0, 0, 1'b0);
    check("R9 drop at end of run", {31'b0, wdata_fault}, 1);
    check("R11 read flag untouched by writes", {31'b0, rd_good}, 0);
    do_abort(1'b0, 1'b0, 1'b1);

    // R3 reserved mode writes
    do_cfg(1, 3, 4'hF, 32'h20, 1'b1, 1'b0, 1'b0);
    push_word(32'h77, 1'b1, 32'h20, 1'b1);
    check("R3 mode 3 stored", mem[8], 32'h77);

    // R5 / R7 mode 1
    do_cfg(2, 1, 4'hF, 32'h10, 1'b1, 1'b0, 1'b0);
    push_word(32'hDEAD0001, 1'b1, 32'h10, 1'b0);
    check("R7 mode 1 match leaves flag", {31'b0, cmp_flag}, 0);
    check("R11 read ok", {31'b0, rd_good}, 1);
    push_word(32'hDEAD0002, 1'b1, 32'h14, 1'b0);
    check("R7 mode 1 mismatch sets flag", {31'b0, cmp_flag}, 1);
    check("R5 target not written", mem[5], 32'hCAFE0002);
    do_abort(1'b0, 1'b1, 1'b0);
    check("R12 abort clears compare", {31'b0, cmp_flag}, 0);

    // R6 masked lanes
    do_cfg(1, 1, 4'b1110, 32'h10, 1'b1, 1'b0, 1'b0);
    push_word(32'hDEAD00FF, 1'b1, 32'h10, 1'b0);
    check("R6 lane 0 excluded", {31'b0, cmp_flag}, 0);

    // R7 mode 2
    do_cfg(2, 2, 4'b0001, 32'h18, 1'b1, 1'b0, 1'b0);
    push_word(32'hFFFFFF03, 1'b1, 32'h18, 1'b0);
    check("R7 mode 2 match sets flag", {31'b0, cmp_flag}, 1);
    do_abort(1'b0, 1'b1, 1'b0);
    push_word(32'h00000001, 1'b1, 32'h1C, 1'b0);
    check("R7 mode 2 mismatch leaves flag", {31'b0, cmp_flag}, 0);
    do_cfg(1, 2, 4'b0000, 32'h14, 1'b1, 1'b0, 1'b0);
    push_word(32'hABCDEF00, 1'b1, 32'h14, 1'b0);
    check("R6 empty mask matches", {31'b0, cmp_flag}, 1);
    do_abort(1'b0, 1'b1, 1'b0);

    // R8 error response
    do_cfg(2, 0, 4'hF, 32'h30, 1'b1, 1'b0, 1'b0);
    inject_err = 1'b1;
    push_word(32'h99, 1'b1, 32'h30, 1'b1);
    check("R8 fault set", {31'b0, fault_flag}, 1);
    check("R8 count kept", 32'(xfer_left), 2);
    push_word(32'h98, 1'b0, 0, 1'b0);
    check("R9 drop while fault", {31'b0, wdata_fault}, 1);
    inject_err = 1'b0;
    do_abort(1'b1, 1'b0, 1'b1);
    check("R12 abort clears fault", {31'b0, fault_flag}, 0);
    push_word(32'h97, 1'b1, 32'h30, 1'b1);
    check("R8 retry same address", mem[12], 32'h97);
    check("R4 count after retry", 32'(xfer_left), 1);
    check("R11 read flag kept over write", {31'b0, rd_good}, 1);

    // R11 read with error
    do_cfg(1, 1, 4'hF, 32'h10, 1'b1, 1'b0, 1'b0);
    inject_err = 1'b1;
    push_word(32'hDEAD0001, 1'b1, 32'h10, 1'b0);
    inject_err = 1'b0;
    check("R11 read error", {31'b0, rd_good}, 0);
    check("R8 fault on read error", {31'b0, fault_flag}, 1);

    // R10 external write-data error
    @(negedge clk); wdata_err = 1'b1;
    @(negedge clk); wdata_err = 1'b0;
    check("R10 wdata error input", {31'b0, wdata_fault}, 1);
    do_abort(1'b0, 1'b0, 1'b1);
    check("R10 cleared again", {31'b0, wdata_fault}, 0);

    // R12 clear styles
    check("R12 self-clear flavour fault held", {31'b0, j_fault}, 1);
    do_cfg(0, 0, 4'hF, 32'h0, 1'b0, 1'b1, 1'b0);
    check("R12 self-clear flavour cleared", {31'b0, j_fault}, 0);
    check("R12 abort flavour ignores flag write", {31'b0, fault_flag}, 1);
    check("R13 clock run off", {31'b0, clk_run_req}, 0);
    do_abort(1'b1, 1'b0, 1'b0);
    check("R12 abort flavour cleared", {31'b0, fault_flag}, 0);

    check("R3 scoreboard drained", 32'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule